// File: doc/BRIEF.md
# Exception Running-Priority and Preemption Unit

This block works out the execution priority at which a microcontroller-class core is currently running. From that value it decides whether the most urgent pending exception may interrupt the code that is running now. Two single-bit masks and a base-priority threshold act on priority levels, not on individual interrupt lines. The block has no separate fast-interrupt path. The threshold is first reduced to its group-priority bits according to a grouping field. The resulting mask level is then combined with the priority of the handler that is already active, and the smaller of the two numbers becomes the running priority.

A pending exception that is valid and whose group priority is numerically below the running priority raises a one-cycle take strobe. The core uses that strobe to start exception entry. After one strobe, no further strobe is issued until the active-handler priority input changes value. This change is the sign that the core has entered the new handler. Priorities are 8-bit unsigned values. The value 0x100 means "none", and the running priority is carried as a signed 10-bit number so that it can hold every value from -1 to 0x100.

Top module: `exc_preempt_core`

## Requirements
- R1: During and directly after a synchronous reset, run_pri_o reads 0x100 and take_o reads 0. The recorded active-handler priority is 0x100 (none).
- R2: When flt_mask_i is 1, the mask level is -1, whatever the other masks are.
- R3: When flt_mask_i is 0 and pri_mask_i is 1, the mask level is 0.
- R4: The base-priority value and the pending priority are each reduced to group bits: with grouping value g, the low min(g+1, 7) bits of the 8-bit priority are cleared. The "none" value 0x100 is kept as it is.
- R5: A reduced base-priority value of zero has no masking effect. A nonzero reduced value becomes the mask level when neither mask bit is set.
- R6: When no mask is in effect, the mask level is 0x100.
- R7: The running priority is the signed minimum of the mask level and act_pri_i, with no offset added to the handler priority.
- R8: An exception is taken only when its reduced pending priority is strictly below the running priority. An equal value never preempts.
- R9: When pend_vld_i is 0, no exception is taken.
- R10: take_o is a single-cycle pulse. After it, take_o stays at 0 until act_pri_i differs from its value at the previous clock edge.
- R11: run_pri_o and take_o are registered. Each reflects the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_mask_i | input | 1 | Fault mask bit; forces the mask level to -1 |
| pri_mask_i | input | 1 | Primary mask bit; forces the mask level to 0 |
| base_pri_i | input | 8 | Base-priority threshold; zero means off |
| pri_grp_i | input | 3 | Priority-grouping field |
| act_pri_i | input | 9 | Priority of the active handler; 0x100 means none |
| pend_pri_i | input | 9 | Priority of the most urgent pending exception |
| pend_vld_i | input | 1 | Pending priority is valid |
| run_pri_o | output | 10 | Signed running priority |
| take_o | output | 1 | One-cycle strobe to take the pending exception |

## Verification
The bench targets these corner cases:
- Grouping values whose truncation turns a nonzero threshold into zero. A design that skipped this reduction, or tested the raw value for zero, would keep masking when it should stop.
- A pending priority equal to the running priority, including equality that appears only after both values are reduced. A design that used a non-strict compare would preempt a handler of the same group.
- The order of precedence of the two mask bits over the threshold, and a handler priority that is below or above the threshold. A design that offset the handler priority, or picked the maximum instead of the minimum, would report the wrong running priority.
- A pending request that is held for several cycles. A design that did not suppress after the strobe would send a train of strobes; one that never released suppression would miss the next, more urgent request after a handler change.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

  // Which term set the mask-derived level.
  typedef enum logic [1:0] {
    MSRC_FAULT = 2'd0,
    MSRC_PRIM  = 2'd1,
    MSRC_BASE  = 2'd2,
    MSRC_NONE  = 2'd3
  } mask_src_e;

  // Extra bits on top of a priority: one for the "none" code, one for sign.
  localparam int RUN_EXTRA = 2;

endpackage

// File: rtl/prio_grp_trunc.sv
module prio_grp_trunc #(
  parameter int PRI_W = 8,
  parameter int GRP_W = 3
) (
  input  logic [PRI_W:0]   val_i,
  input  logic [GRP_W-1:0] grp_i,
  output logic [PRI_W:0]   grp_val_o
);
  localparam int MAX_DROP = PRI_W - 1;

  int unsigned drop;

  always_comb begin
    drop = 32'(grp_i) + 1;
    if (drop > MAX_DROP) drop = MAX_DROP;
    grp_val_o = val_i;
    for (int b = 0; b < PRI_W; b++) begin
      if (b < drop) grp_val_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/prio_mask_level.sv
module prio_mask_level
  import exc_prio_pkg::*;
#(
  parameter int PRI_W = 8,
  parameter int RUN_W = PRI_W + RUN_EXTRA
) (
  input  logic                    flt_mask_i,
  input  logic                    pri_mask_i,
  input  logic [PRI_W:0]          base_grp_i,
  output logic signed [RUN_W-1:0] level_o,
  output mask_src_e               src_o
);
  localparam logic signed [RUN_W-1:0] LVL_NONE = RUN_W'(1 << PRI_W);

  always_comb begin
    if (flt_mask_i) begin
      src_o   = MSRC_FAULT;
      level_o = '1;
    end else if (pri_mask_i) begin
      src_o   = MSRC_PRIM;
      level_o = '0;
    end else if (base_grp_i[PRI_W-1:0] != '0) begin
      src_o   = MSRC_BASE;
      level_o = $signed({2'b00, base_grp_i[PRI_W-1:0]});
    end else begin
      src_o   = MSRC_NONE;
      level_o = LVL_NONE;
    end
  end

endmodule

// File: rtl/prio_take_ctl.sv
module prio_take_ctl #(
  parameter int PRI_W = 8,
  parameter int RUN_W = PRI_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PRI_W:0]          pend_grp_i,
  input  logic                    pend_vld_i,
  input  logic signed [RUN_W-1:0] run_i,
  input  logic [PRI_W:0]          act_pri_i,
  output logic                    take_o
);
  localparam logic [PRI_W:0] PRI_NONE = (PRI_W+1)'(1 << PRI_W);

  logic [PRI_W:0] act_q;
  logic           hold_q;
  logic           act_chg;
  logic           beats;
  logic           take_d;

  always_comb begin
    act_chg = (act_pri_i != act_q);
    beats   = $signed({1'b0, pend_grp_i}) < run_i;
    take_d  = pend_vld_i && beats && (!hold_q || act_chg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= PRI_NONE;
      hold_q <= 1'b0;
      take_o <= 1'b0;
    end else begin
      act_q  <= act_pri_i;
      take_o <= take_d;
      if (take_d)       hold_q <= 1'b1;
      else if (act_chg) hold_q <= 1'b0;
    end
  end

endmodule

// File: rtl/exc_preempt_core.sv
module exc_preempt_core
  import exc_prio_pkg::*;
#(
  parameter int PRI_W = 8,
  parameter int GRP_W = 3,
  localparam int RUN_W = PRI_W + RUN_EXTRA
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flt_mask_i,
  input  logic                    pri_mask_i,
  input  logic [PRI_W-1:0]        base_pri_i,
  input  logic [GRP_W-1:0]        pri_grp_i,
  input  logic [PRI_W:0]          act_pri_i,
  input  logic [PRI_W:0]          pend_pri_i,
  input  logic                    pend_vld_i,
  output logic signed [RUN_W-1:0] run_pri_o,
  output logic                    take_o
);
  localparam int N_TRUNC = 2;
  localparam logic signed [RUN_W-1:0] RUN_NONE = RUN_W'(1 << PRI_W);

  logic [PRI_W:0] raw_v   [N_TRUNC];
  logic [PRI_W:0] grp_v   [N_TRUNC];

  assign raw_v[0] = {1'b0, base_pri_i};
  assign raw_v[1] = pend_pri_i;

  for (genvar k = 0; k < N_TRUNC; k++) begin : g_trunc
    prio_grp_trunc #(.PRI_W(PRI_W), .GRP_W(GRP_W)) trunc_i (
      .val_i     (raw_v[k]),
      .grp_i     (pri_grp_i),
      .grp_val_o (grp_v[k])
    );
  end

  logic signed [RUN_W-1:0] mask_lvl;
  mask_src_e               mask_src;
  logic signed [RUN_W-1:0] act_s;
  logic signed [RUN_W-1:0] run_c;

  prio_mask_level #(.PRI_W(PRI_W), .RUN_W(RUN_W)) mask_i (
    .flt_mask_i (flt_mask_i),
    .pri_mask_i (pri_mask_i),
    .base_grp_i (grp_v[0]),
    .level_o    (mask_lvl),
    .src_o      (mask_src)
  );

  always_comb begin
    act_s = $signed({1'b0, act_pri_i});
    run_c = (act_s < mask_lvl) ? act_s : mask_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) run_pri_o <= RUN_NONE;
    else     run_pri_o <= run_c;
  end

  prio_take_ctl #(.PRI_W(PRI_W), .RUN_W(RUN_W)) take_i (
    .clk        (clk),
    .rst        (rst),
    .pend_grp_i (grp_v[1]),
    .pend_vld_i (pend_vld_i),
    .run_i      (run_c),
    .act_pri_i  (act_pri_i),
    .take_o     (take_o)
  );

  logic unused_src;
  assign unused_src = ^mask_src;

endmodule

// File: rtl/exc_preempt_core_chk.sv
module exc_preempt_core_chk #(
  parameter int PRI_W = 8,
  parameter int GRP_W = 3,
  parameter int RUN_W = PRI_W + 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    flt_mask_i,
  input logic                    pri_mask_i,
  input logic [PRI_W-1:0]        base_pri_i,
  input logic [GRP_W-1:0]        pri_grp_i,
  input logic [PRI_W:0]          act_pri_i,
  input logic [PRI_W:0]          pend_pri_i,
  input logic                    pend_vld_i,
  input logic signed [RUN_W-1:0] run_pri_o,
  input logic                    take_o
);
  localparam logic signed [RUN_W-1:0] RUN_NONE = RUN_W'(1 << PRI_W);
  localparam logic [PRI_W:0]          PRI_NONE = (PRI_W+1)'(1 << PRI_W);

  assert_fault_level_R2: assert property (@(posedge clk) disable iff (rst)
    flt_mask_i |=> run_pri_o == -1);

  assert_prim_level_R3: assert property (@(posedge clk) disable iff (rst)
    (!flt_mask_i && pri_mask_i) |=> run_pri_o == 0);

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!flt_mask_i && !pri_mask_i && base_pri_i == '0 && act_pri_i == PRI_NONE)
      |=> run_pri_o == RUN_NONE);

  assert_run_range_R7: assert property (@(posedge clk) disable iff (rst)
    (run_pri_o >= -1) && (run_pri_o <= RUN_NONE));

  assert_take_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(pend_vld_i));

  assert_take_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (take_o && $past(take_o)) |-> ($past(act_pri_i) != $past(act_pri_i, 2)));

endmodule

bind exc_preempt_core exc_preempt_core_chk #(
  .PRI_W(PRI_W), .GRP_W(GRP_W), .RUN_W(RUN_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .flt_mask_i (flt_mask_i),
  .pri_mask_i (pri_mask_i),
  .base_pri_i (base_pri_i),
  .pri_grp_i  (pri_grp_i),
  .act_pri_i  (act_pri_i),
  .pend_pri_i (pend_pri_i),
  .pend_vld_i (pend_vld_i),
  .run_pri_o  (run_pri_o),
  .take_o     (take_o)
);

// File: tb/exc_preempt_core_tb.sv
`timescale 1ns/1ps
module exc_preempt_core_tb_top;
  localparam int NONE = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flt = 1'b0;
  logic              prm = 1'b0;
  logic [7:0]        bpri = '0;
  logic [2:0]        grp = '0;
  logic [8:0]        act = 9'h100;
  logic [8:0]        pend = 9'h100;
  logic              vld = 1'b0;
  logic signed [9:0] run_pri;
  logic              take;

  int n_chk = 0;
  int n_bad = 0;
  int m_prev_act = NONE;
  bit m_hold = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_preempt_core dut_i (
    .clk(clk), .rst(rst), .flt_mask_i(flt), .pri_mask_i(prm),
    .base_pri_i(bpri), .pri_grp_i(grp), .act_pri_i(act),
    .pend_pri_i(pend), .pend_vld_i(vld), .run_pri_o(run_pri), .take_o(take)
  );

  function automatic int to_grp(int v, int g);
    int d;
    d = (g + 1 > 7) ? 7 : g + 1;
    if (v == NONE) return NONE;
    return (v >> d) << d;
  endfunction

  function automatic int model_run();
    int lvl;
    int bt;
    bt = to_grp(int'(bpri), int'(grp));
    if (flt)          lvl = -1;
    else if (prm)     lvl = 0;
    else if (bt != 0) lvl = bt;
    else              lvl = NONE;
    return (int'(act) < lvl) ? int'(act) : lvl;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // Apply current inputs for one clock and compare both registered outputs.
  task automatic step(string req);
    int  e_run;
    bit  chg;
    bit  e_take;
    e_run  = model_run();
    chg    = (int'(act) != m_prev_act);
    e_take = vld && (to_grp(int'(pend), int'(grp)) < e_run) && (!m_hold || chg);
    if (e_take)   m_hold = 1'b1;
    else if (chg) m_hold = 1'b0;
    m_prev_act = int'(act);
    @(posedge clk);
    #1;
    check({req, " run"}, int'(run_pri), e_run);
    check({req, " take"}, int'(take), int'(e_take));
    @(negedge clk);
  endtask

  task automatic set_in(bit f, bit p, int b, int g, int a, int pe, bit v);
    flt = f; prm = p; bpri = 8'(b); grp = 3'(g);
    act = 9'(a); pend = 9'(pe); vld = v;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    set_in(0, 0, 0, 0, NONE, NONE, 0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 run", int'(run_pri), NONE);
    check("R1 take", int'(take), 0);
    @(negedge clk);
    rst = 1'b0;
    m_prev_act = NONE;
    m_hold = 1'b0;
    step("R6 idle");
  endtask

  task automatic t_masks();
    set_in(1, 1, 8'h40, 0, 9'h20, 0, 1);   step("R2 fault over all");
    set_in(0, 1, 8'h40, 0, 9'h20, 0, 1);   step("R3 prim mask");
    set_in(1, 0, 0, 0, NONE, NONE, 0);     step("R2 fault alone");
    set_in(0, 0, 0, 0, NONE, NONE, 0);     step("R6 no mask");
  endtask

  task automatic t_base();
    set_in(0, 0, 8'h41, 0, NONE, NONE, 0); step("R4 g0 drop1");
    set_in(0, 0, 8'h4F, 3, NONE, NONE, 0); step("R4 g3 drop4");
    set_in(0, 0, 8'h81, 7, NONE, NONE, 0); step("R4 g7 saturate");
    set_in(0, 0, 8'h7F, 6, NONE, NONE, 0); step("R5 trunc to zero");
    set_in(0, 0, 8'h01, 0, NONE, NONE, 0); step("R5 trunc one to zero");
  endtask

  task automatic t_min();
    set_in(0, 0, 8'h60, 0, 9'h30, NONE, 0); step("R7 handler lower");
    set_in(0, 0, 8'h60, 0, 9'h90, NONE, 0); step("R7 mask lower");
    set_in(0, 0, 0, 0, 9'h05, NONE, 0);     step("R7 no offset");
  endtask

  task automatic t_take();
    set_in(0, 0, 0, 0, NONE, 9'h50, 1);     step("R8 take");
    step("R10 held request suppressed");
    step("R10 still suppressed");
    set_in(0, 0, 0, 0, 9'h50, 9'h50, 1);    step("R8 equal no preempt");
    set_in(0, 0, 0, 0, 9'h50, 9'h20, 1);    step("R8 lower preempts");
    set_in(0, 0, 0, 0, 9'h20, 9'h10, 0);    step("R9 invalid");
    set_in(0, 0, 0, 2, 9'h40, 9'h47, 1);    step("R4 pend grouped equal");
    set_in(0, 0, 0, 2, 9'h40, 9'h38, 1);    step("R8 pend grouped lower");
    set_in(0, 1, 0, 0, 9'h30, 9'h00, 1);    step("R3 prim blocks zero");
    set_in(1, 0, 0, 0, 9'h31, 9'h00, 1);    step("R2 fault blocks");
  endtask

  task automatic t_latency();
    set_in(0, 0, 8'h80, 0, NONE, NONE, 0);
    @(posedge clk); #1;
    check("R11 one edge", int'(run_pri), 8'h80);
    @(negedge clk);
    m_prev_act = NONE;
    set_in(1, 0, 8'h80, 0, NONE, NONE, 0);
    #1;
    check("R11 not before edge", int'(run_pri), 8'h80);
    step("R11 after edge");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_masks();
    t_base();
    t_min();
    t_take();
    t_latency();
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule